// File: doc/BRIEF.md
# SDRAM Power-On Initialization Sequencer

This block drives the command, clock-enable, data-mask and address/bank pins of a synchronous DRAM from reset until the memory is ready for traffic. After reset it holds a long idle pause, with clock enable and every data-mask bit high. The pause length is computed from the clock frequency. It then closes all banks, programs the mode register and issues a configurable number of auto-refresh commands. Finally it raises a ready flag, and from then on a normal memory controller owns the bus.

The refresh burst can be placed before or after the mode-register load. Each command occupies a single clock. The spacing between commands (precharge recovery, refresh cycle time, mode-load recovery) is set by parameters and is filled with idle cycles.

Top module: `sdram_init_seq`

## Requirements
- R1: While `rst_n` is low, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `cke` is 1, every `dqm` bit is 1 and `ready` is 0.
- R2: After reset is released, NOP is held for PAUSE_CYC = CLK_MHZ*PAUSE_US clocks. The first command appears on the pins after rising edge PAUSE_CYC+1.
- R3: `cke` and all `dqm` bits stay at 1 through the pause and the whole command sequence, until `ready` rises.
- R4: The first command is precharge-all: command code 4'b0010 with address bit 10 set to 1.
- R5: The mode-register load is command code 4'b0000 with `addr` equal to MODE_VALUE and `ba` equal to 0. With REFRESH_FIRST=0 it follows the precharge by exactly T_RP clocks.
- R6: Exactly NUM_REFRESH auto-refresh commands (code 4'b0001) are issued, each T_RFC clocks after the previous one.
- R7: The command after a mode-register load comes exactly T_MRD clocks later, and the cycles in between are NOP.
- R8: With REFRESH_FIRST=1, the refreshes start T_RP clocks after the precharge, the mode load follows the last refresh by T_RFC clocks, and `ready` rises T_MRD clocks after the mode load.
- R9: `ready` rises exactly one gap after the last command: T_RFC after the last refresh when REFRESH_FIRST=0, or T_MRD after the mode load when REFRESH_FIRST=1. It then stays high until reset, with NOP on the pins, `dqm` at 0 and `cke` at 1.
- R10: Every command lasts one clock, and every cycle between commands is NOP. All gaps are at least 2 clocks.
- R11: Asserting reset in the middle of the sequence restarts it from the full pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | DQM_W | Data mask, high during initialization |
| addr | output | ADDR_W | Address lines (bit 10 marks precharge-all) |
| ba | output | BA_W | Bank address |
| ready | output | 1 | Initialization complete |

## Verification
Every output is registered. A command therefore appears after the rising edge at which its gap counter expires: the precharge after edge PAUSE_CYC+1 counted from reset release, and each later command exactly one programmed gap after the one before it, with `ready` due one final gap after the last command. The bench releases reset on a falling edge, counts rising edges from there, and samples on the falling edge after each counted edge. It expects NOP in every intermediate cycle and the command itself in the exact cycle given by an expected-sequence table. Two instances cover both refresh orderings, and a reset issued after the precharge confirms that the full pause is counted again.

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int CLK_MHZ       = 143,
  parameter int PAUSE_US      = 200,
  parameter int T_RP          = 3,
  parameter int T_RFC         = 10,
  parameter int T_MRD         = 2,
  parameter int NUM_REFRESH   = 8,
  parameter bit REFRESH_FIRST = 1'b0,
  parameter int ADDR_W        = 12,
  parameter int BA_W          = 2,
  parameter int DQM_W         = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h032
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              ready
);
  localparam int PAUSE_CYC = CLK_MHZ * PAUSE_US;
  localparam int GAP_MAX   = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int CNT_MAX   = (PAUSE_CYC > GAP_MAX) ? PAUSE_CYC : GAP_MAX;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam int RC_W      = $clog2(NUM_REFRESH + 1);

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {ST_PAUSE, ST_PRE_GAP, ST_MRS_GAP, ST_REF_GAP, ST_DONE} st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt;
  logic [RC_W-1:0]   rcnt;
  logic [3:0]        cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ready_q;

  assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
  assign cke   = 1'b1;
  assign dqm   = {DQM_W{~ready_q}};
  assign addr  = addr_q;
  assign ba    = '0;
  assign ready = ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_PAUSE;
      cnt     <= CNT_W'(PAUSE_CYC);
      rcnt    <= '0;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        case (st)
          ST_PAUSE: begin
            cmd_q      <= CMD_PRE;
            addr_q[10] <= 1'b1;
            cnt        <= CNT_W'(T_RP - 1);
            st         <= ST_PRE_GAP;
          end
          ST_PRE_GAP: begin
            if (REFRESH_FIRST) begin
              cmd_q <= CMD_REF;
              rcnt  <= RC_W'(1);
              cnt   <= CNT_W'(T_RFC - 1);
              st    <= ST_REF_GAP;
            end else begin
              cmd_q  <= CMD_MRS;
              addr_q <= MODE_VALUE;
              cnt    <= CNT_W'(T_MRD - 1);
              st     <= ST_MRS_GAP;
            end
          end
          ST_REF_GAP: begin
            if (rcnt < RC_W'(NUM_REFRESH)) begin
              cmd_q <= CMD_REF;
              rcnt  <= rcnt + 1'b1;
              cnt   <= CNT_W'(T_RFC - 1);
            end else if (REFRESH_FIRST) begin
              cmd_q  <= CMD_MRS;
              addr_q <= MODE_VALUE;
              cnt    <= CNT_W'(T_MRD - 1);
              st     <= ST_MRS_GAP;
            end else begin
              ready_q <= 1'b1;
              st      <= ST_DONE;
            end
          end
          ST_MRS_GAP: begin
            if (REFRESH_FIRST) begin
              ready_q <= 1'b1;
              st      <= ST_DONE;
            end else begin
              cmd_q <= CMD_REF;
              rcnt  <= RC_W'(1);
              cnt   <= CNT_W'(T_RFC - 1);
              st    <= ST_REF_GAP;
            end
          end
          default: st <= ST_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int PAUSE_CYC   = 1000,
  parameter int NUM_REFRESH = 8,
  parameter int ADDR_W      = 12,
  parameter int BA_W        = 2,
  parameter int DQM_W       = 2,
  parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic              cke,
  input logic [DQM_W-1:0]  dqm,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   ba,
  input logic              ready
);
  logic [31:0] cyc;
  logic [15:0] refs;
  logic        mrs_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc      <= '0;
      refs     <= '0;
      mrs_seen <= 1'b0;
    end else begin
      if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 1'b1;
      if (cmd == 4'b0001) refs <= refs + 1'b1;
      if (cmd == 4'b0000) mrs_seen <= 1'b1;
    end
  end

  p_pause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |-> (cyc > 32'(PAUSE_CYC)));
  p_cke_dqm_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (cke && (&dqm)));
  p_pre_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0010) |-> addr[10]);
  p_mode_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 4'b0000) |-> (addr == MODE_VALUE && ba == '0));
  p_ref_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (refs == 16'(NUM_REFRESH) && mrs_seen));
  p_ready_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (cmd == 4'b0111 && dqm == '0 && cke));
  p_single_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd != 4'b0111) |=> (cmd == 4'b0111));
endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .PAUSE_CYC(PAUSE_CYC), .NUM_REFRESH(NUM_REFRESH), .ADDR_W(ADDR_W),
  .BA_W(BA_W), .DQM_W(DQM_W), .MODE_VALUE(MODE_VALUE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd({cs_n, ras_n, cas_n, we_n}), .cke(cke),
  .dqm(dqm), .addr(addr), .ba(ba), .ready(ready)
);

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;
  localparam int CLK_MHZ  = 125;
  localparam int PAUSE_US = 2;
  localparam int P        = CLK_MHZ * PAUSE_US;
  localparam int T_RP     = 3;
  localparam int T_RFC    = 7;
  localparam int T_MRD    = 2;
  localparam int NREF     = 8;
  localparam logic [11:0] MODE = 12'h037;

  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  typedef struct packed { logic [15:0] gap; logic [3:0] cmd; } vec_t;

  localparam vec_t TBL_A [10] = '{
    '{16'(P + 1), PRE}, '{16'(T_RP), MRS}, '{16'(T_MRD), REF},
    '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), REF},
    '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), REF}};
  localparam vec_t TBL_B [10] = '{
    '{16'(P + 1), PRE}, '{16'(T_RP), REF},
    '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), REF},
    '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), REF}, '{16'(T_RFC), MRS}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic a_cs, a_ras, a_cas, a_we, a_cke, a_rdy;
  logic b_cs, b_ras, b_cas, b_we, b_cke, b_rdy;
  logic [1:0] a_dqm, b_dqm, a_ba, b_ba;
  logic [11:0] a_addr, b_addr;

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .NUM_REFRESH(NREF), .REFRESH_FIRST(1'b0), .MODE_VALUE(MODE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
    .cke(a_cke), .dqm(a_dqm), .addr(a_addr), .ba(a_ba), .ready(a_rdy));

  sdram_init_seq #(.CLK_MHZ(CLK_MHZ), .PAUSE_US(PAUSE_US), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .NUM_REFRESH(NREF), .REFRESH_FIRST(1'b1), .MODE_VALUE(MODE)) u_dut_alt (
    .clk(clk), .rst_n(rst_n), .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
    .cke(b_cke), .dqm(b_dqm), .addr(b_addr), .ba(b_ba), .ready(b_rdy));

  logic sel = 1'b0;
  wire [3:0]  cmd  = sel ? {b_cs, b_ras, b_cas, b_we} : {a_cs, a_ras, a_cas, a_we};
  wire        cke  = sel ? b_cke : a_cke;
  wire [1:0]  dqm  = sel ? b_dqm : a_dqm;
  wire [11:0] addr = sel ? b_addr : a_addr;
  wire [1:0]  ba   = sel ? b_ba : a_ba;
  wire        rdy  = sel ? b_rdy : a_rdy;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    sel = 1'b0;
    check(cmd == NOP && cke && dqm == 2'b11 && !rdy, "R1 reset A", {cmd, 2'b0, dqm, 3'b0, rdy}, {NOP, 2'b0, 2'b11, 4'b0});
    sel = 1'b1;
    check(cmd == NOP && cke && dqm == 2'b11 && !rdy, "R1 reset B", {cmd, 2'b0, dqm, 3'b0, rdy}, {NOP, 2'b0, 2'b11, 4'b0});
    rst_n = 1'b1;
  endtask

  task automatic run_seq(input bit alt);
    bit bad;
    int last_gap;
    sel = alt;
    for (int i = 0; i < 10; i++) begin
      vec_t v;
      v = alt ? TBL_B[i] : TBL_A[i];
      bad = 1'b0;
      for (int j = 1; j < int'(v.gap); j++) begin
        @(negedge clk);
        if (cmd != NOP || !cke || dqm != 2'b11 || rdy) bad = 1'b1;
      end
      check(!bad, i == 0 ? "R2/R3 pause NOP" : "R10/R3 gap NOP", {31'b0, bad}, 32'd0);
      @(negedge clk);
      case (v.cmd)
        PRE: check(cmd == PRE && addr[10], "R4 precharge-all", {cmd, addr}, {PRE, 12'h400});
        MRS: check(cmd == MRS && addr == MODE && ba == 2'b00, alt ? "R8 mode load order" : "R5 mode load",
                   {cmd, addr}, {MRS, MODE});
        default: check(cmd == REF, alt ? "R8 refresh order" : (i == 2 ? "R7 gap after mode" : "R6 refresh"),
                       {28'b0, cmd}, {28'b0, REF});
      endcase
      check(cke && dqm == 2'b11 && !rdy, "R3 cke/dqm high", {cke, dqm, rdy}, 4'b1110);
    end
    last_gap = alt ? T_MRD : T_RFC;
    bad = 1'b0;
    for (int j = 1; j < last_gap; j++) begin
      @(negedge clk);
      if (rdy || cmd != NOP) bad = 1'b1;
    end
    check(!bad, alt ? "R8 ready not early" : "R9 ready not early", {31'b0, bad}, 32'd0);
    @(negedge clk);
    check(rdy, alt ? "R8 ready rise" : "R9 ready rise", {31'b0, rdy}, 32'd1);
    bad = 1'b0;
    for (int j = 0; j < 20; j++) begin
      if (!rdy || cmd != NOP || dqm != 2'b00 || !cke) bad = 1'b1;
      @(negedge clk);
    end
    check(!bad, "R9 ready held idle", {31'b0, bad}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    run_seq(1'b0);
    do_reset();
    run_seq(1'b1);
    // R11: reset after the precharge has gone out, then the whole sequence again
    do_reset();
    sel = 1'b0;
    repeat (P + 5) @(negedge clk);
    do_reset();
    check(cmd == NOP && !rdy, "R11 restart idle", {28'b0, cmd}, {28'b0, NOP});
    run_seq(1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule